// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit makes the three per-descriptor decisions of a descriptor-driven DMA channel: whether the channel stalls on the current descriptor, whether it branches instead of moving to the next descriptor in sequence, and whether it raises an interrupt. Each decision has its own 2-bit mode field in the command word and its own select register. A select register carries a 4-bit mask and a 4-bit compare value, which are matched against the low nibble of the device-status byte.

The channel sequencer samples the stall and branch flags combinationally in the same cycle it presents the command. When it pulses the completion strobe, the unit issues a one-cycle interrupt request in the following cycle, provided the interrupt decision is true and the descriptor is not stalled. A stalled descriptor does not complete, so it produces no interrupt. When the branch flag is low, the channel advances to the next descriptor in sequence.

Top module: `desc_cond_eval`

## Requirements
- R1: In each select register the mask sits in bits [19:16] and the compare value in bits [3:0]. All other select bits have no effect on any output.
- R2: The match condition is true when (status[3:0] & mask) == (value & mask). Status bits [7:4] have no effect, and a zero mask makes the condition true.
- R3: Every decision uses the same mode code: 0 gives false, 1 gives the match condition, 2 gives its inverse, and 3 gives true.
- R4: `stall_o` is the decision for mode bits cmd_ctl[1:0] using `wait_sel`. It is combinational in the same cycle.
- R5: `branch_o` is the decision for mode bits cmd_ctl[3:2] using `br_sel`. It is combinational in the same cycle, and a low value means sequential advance.
- R6: The interrupt decision uses mode bits cmd_ctl[5:4] and `irq_sel`.
- R7: `irq_o` is high for exactly the one cycle after a clock edge at which `done_stb` was high and the interrupt decision was true. At all other times it is low.
- R8: A strobe taken while `stall_o` is high produces no interrupt.
- R9: While `rst_n` is low, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ctl | input | 6 | Mode fields: [5:4] interrupt, [3:2] branch, [1:0] stall |
| dev_status | input | 8 | Device-status byte |
| irq_sel | input | 32 | Interrupt select register |
| br_sel | input | 32 | Branch select register |
| wait_sel | input | 32 | Stall select register |
| done_stb | input | 1 | Descriptor completion strobe |
| stall_o | output | 1 | Stall decision |
| branch_o | output | 1 | Branch decision |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is a completion strobe where the interrupt decision is true and the stall decision is also true at the same moment, because both depend on the same status nibble through different masks. The stimulus builds this case directly: it sets the interrupt mode to always and the stall mode to match, with a matching stall select. It also sends back-to-back strobes to check that consecutive pulses stay one cycle each. Beyond those directed cases, random commands, status bytes and select words, including junk in the unused select bits, are compared against a behavioural model every cycle.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int NUM_DEC  = 3;   // lane 0 stall, 1 branch, 2 interrupt
  localparam int MODE_W   = 2;
  localparam int COND_W   = 4;
  localparam int MASK_LSB = 16;
  localparam int VAL_LSB  = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_NEVER   = 2'd0,
    MODE_ON_TRUE = 2'd1,
    MODE_ON_FALS = 2'd2,
    MODE_ALWAYS  = 2'd3
  } cond_mode_e;
endpackage

// File: rtl/dce_match.sv
module dce_match #(
  parameter int SEL_W  = 32,
  parameter int STAT_W = 8
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [STAT_W-1:0] status,
  output logic              hit
);
  import dce_pkg::*;
  logic [COND_W-1:0] mask_f, val_f, stat_f;
  always_comb begin
    mask_f = sel[MASK_LSB +: COND_W];
    val_f  = sel[VAL_LSB  +: COND_W];
    stat_f = status[COND_W-1:0];
    hit    = ((stat_f & mask_f) == (val_f & mask_f));
  end
endmodule

// File: rtl/dce_decide.sv
module dce_decide (
  input  logic [dce_pkg::MODE_W-1:0] mode,
  input  logic                       hit,
  output logic                       dec
);
  import dce_pkg::*;
  always_comb begin
    unique case (cond_mode_e'(mode))
      MODE_NEVER:   dec = 1'b0;
      MODE_ON_TRUE: dec = hit;
      MODE_ON_FALS: dec = ~hit;
      MODE_ALWAYS:  dec = 1'b1;
      default:      dec = 1'b0;
    endcase
  end
endmodule

// File: rtl/dce_irq_pulse.sv
module dce_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic stalled,
  input  logic want_irq,
  output logic irq
);
  logic irq_d, irq_q, irq_en;

  always_comb begin
    irq_en = strobe | irq_q;
    irq_d  = strobe & ~stalled & want_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/desc_cond_eval.sv
module desc_cond_eval #(
  parameter int SEL_W  = 32,
  parameter int STAT_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [dce_pkg::NUM_DEC*dce_pkg::MODE_W-1:0] cmd_ctl,
  input  logic [STAT_W-1:0]                      dev_status,
  input  logic [SEL_W-1:0]                       irq_sel,
  input  logic [SEL_W-1:0]                       br_sel,
  input  logic [SEL_W-1:0]                       wait_sel,
  input  logic                                   done_stb,
  output logic                                   stall_o,
  output logic                                   branch_o,
  output logic                                   irq_o
);
  import dce_pkg::*;
  localparam int LANE_STALL = 0;
  localparam int LANE_BR    = 1;
  localparam int LANE_IRQ   = 2;

  logic [SEL_W-1:0]   sel_arr [NUM_DEC];
  logic [NUM_DEC-1:0] hit_v, dec_v;

  always_comb begin
    sel_arr[LANE_STALL] = wait_sel;
    sel_arr[LANE_BR]    = br_sel;
    sel_arr[LANE_IRQ]   = irq_sel;
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_lane
    dce_match #(.SEL_W(SEL_W), .STAT_W(STAT_W)) u_match (
      .sel(sel_arr[g]), .status(dev_status), .hit(hit_v[g]));
    dce_decide u_dec (
      .mode(cmd_ctl[g*MODE_W +: MODE_W]), .hit(hit_v[g]), .dec(dec_v[g]));
  end

  assign stall_o  = dec_v[LANE_STALL];
  assign branch_o = dec_v[LANE_BR];

  dce_irq_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .strobe(done_stb),
    .stalled(dec_v[LANE_STALL]), .want_irq(dec_v[LANE_IRQ]), .irq(irq_o));

  // R7
  irq_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(done_stb));
  // R8
  irq_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(stall_o));
  // R3
  irq_never_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ctl[5:4] == 2'd0) |=> !irq_o);
  // R4
  stall_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ctl[1:0] == 2'd3) |-> stall_o);
  // R5
  branch_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ctl[3:2] == 2'd0) |-> !branch_o);
  // R7
  irq_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb && cmd_ctl[5:4] == 2'd3 && !stall_o) |=> irq_o);
endmodule

// File: tb/tb_desc_cond_eval.sv
`timescale 1ns/1ps
module tb_desc_cond_eval;
  logic clk = 1'b0;
  logic rst_n;
  logic [5:0]  cmd_ctl;
  logic [7:0]  dev_status;
  logic [31:0] irq_sel, br_sel, wait_sel;
  logic done_stb;
  logic stall_o, branch_o, irq_o;

  int checks = 0, fails = 0;
  bit exp_irq = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  desc_cond_eval dut (.clk(clk), .rst_n(rst_n), .cmd_ctl(cmd_ctl),
    .dev_status(dev_status), .irq_sel(irq_sel), .br_sel(br_sel),
    .wait_sel(wait_sel), .done_stb(done_stb), .stall_o(stall_o),
    .branch_o(branch_o), .irq_o(irq_o));

  function automatic bit ref_dec(input int mode, input logic [31:0] sel,
                                 input logic [7:0] st);
    int m, v, s;
    bit c;
    m = (sel >> 16) % 16;
    v = sel % 16;
    s = st % 16;
    c = ((s & m) == (v & m));
    case (mode)
      0: return 1'b0;
      1: return c;
      2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, compare prior irq, then comb outputs
  task automatic step(input logic [5:0] c, input logic [7:0] st,
                      input logic [31:0] si, input logic [31:0] sb,
                      input logic [31:0] sw, input bit stb, input string req);
    bit ew;
    @(negedge clk);
    chk(irq_o, exp_irq, "R7/R8 irq");
    cmd_ctl = c; dev_status = st; irq_sel = si; br_sel = sb;
    wait_sel = sw; done_stb = stb;
    #1;
    ew = ref_dec(c[1:0], sw, st);
    chk(stall_o, ew, {req, " R4 stall"});
    chk(branch_o, ref_dec(c[3:2], sb, st), {req, " R5 branch"});
    exp_irq = stb && !ew && ref_dec(c[5:4], si, st);
  endtask

  initial begin
    rst_n = 1'b0; cmd_ctl = '0; dev_status = '0; irq_sel = '0;
    br_sel = '0; wait_sel = '0; done_stb = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(irq_o, 1'b0, "R9 reset");
    @(negedge clk); rst_n = 1'b1;
    // R1/R2: mask 0xF value 5, status 0x?5 match, upper status ignored
    step(6'b01_01_01, 8'hF5, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 1'b0, "R1 match");
    step(6'b01_01_10, 8'h35, 32'hFFF0_FFF5, 32'h000F_0006, 32'h000F_0005, 1'b1, "R2 junk bits R10");
    // R2 zero mask always true
    step(6'b10_10_10, 8'h0A, 32'h0000_0003, 32'h0000_0003, 32'h0000_0003, 1'b1, "R2 zero mask");
    // R3 mode sweep
    for (int md = 0; md < 4; md++)
      step(6'({2'(md), 2'(md), 2'd0}), 8'h02, 32'h0002_0000, 32'h0002_0000, 32'h0, 1'b1, "R3 modes");
    // R8: irq always but stall true
    step(6'b11_00_01, 8'h01, 32'h0, 32'h0, 32'h0001_0001, 1'b1, "R8 stalled");
    // R6/R7 back-to-back strobes
    step(6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0, 1'b1, "R6 b2b");
    step(6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0, 1'b1, "R6 b2b");
    step(6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0, 1'b0, "R7 no stb");
    step(6'b00_00_00, 8'h00, 32'h0, 32'h0, 32'h0, 1'b0, "R7 idle");
    for (int i = 0; i < 400; i++)
      step(6'($urandom), 8'($urandom), $urandom, $urandom, $urandom,
           1'($urandom), "rand");
    @(negedge clk);
    chk(irq_o, exp_irq, "R7 final");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule